// File: doc/BRIEF.md
# Overflow and Bounds Trap Checker

The block decides whether an instruction that checks for arithmetic overflow or for an array-index overrun has to raise a software trap. It produces a trap request: an 8-bit vector with a one-cycle valid pulse. When no trap is needed it gives a one-cycle completion pulse instead. Dispatching the trap is left to the surrounding core.

An overflow check is resolved at once from the incoming overflow flag. A bounds check first latches the tested value, the operand size and a byte base address. It then fetches two signed limits from memory: the lower limit at the base address, and the upper limit right after it. It compares the tested value against both limits. Operands are 16-bit or 32-bit. In 16-bit mode the value and the limits are taken from the low halves of their words. A bounds check whose limit operand is encoded as a register is refused with an invalid-operand fault and reads no memory.

The controller is a state machine with seven states:

| State | Role |
|---|---|
| `ST_IDLE` | Waits for `start`. |
| `ST_REQ_LO` | Issues the read of the lower limit. |
| `ST_WAIT_LO` | Waits for the lower-limit data. |
| `ST_REQ_HI` | Issues the read of the upper limit. |
| `ST_WAIT_HI` | Waits for the upper-limit data. |
| `ST_EVAL` | Compares the value against the limits. |
| `ST_FINISH` | Reports the verdict. |

Its transitions:

- **IDLE to FINISH** on an overflow check, or on a bounds check with a register-encoded limit operand.
- **IDLE to REQ_LO** on a bounds check with a memory limit operand.
- **REQ_LO to WAIT_LO** unconditionally.
- **WAIT_LO to REQ_HI** when read data returns.
- **REQ_HI to WAIT_HI** unconditionally.
- **WAIT_HI to EVAL** when read data returns.
- **EVAL to FINISH** unconditionally.
- **FINISH to IDLE** unconditionally.

Top module: `trap_checker`

## Requirements
- R1: An overflow check (`op_bound`=0) with `of_flag`=1 ends with `trap_valid` and `trap_vec`=0x04.
- R2: An overflow check with `of_flag`=0 ends with `done` and no trap, and it issues no memory read.
- R3: A bounds check (`op_bound`=1) whose signed value is below the lower limit or above the upper limit ends with `trap_valid` and `trap_vec`=0x05.
- R4: A value equal to either limit, or lying strictly between them, ends with `done` and no trap.
- R5: A bounds check with `lim_is_reg`=1 ends with `trap_valid`, `trap_vec`=0x06 and `bad_operand`=1, and it issues no memory read.
- R6: A bounds check issues exactly two single-cycle reads, one at a time:
  - the first reads the lower limit at `base_addr`;
  - the second reads the upper limit at `base_addr`+2 when `wide`=0, or at `base_addr`+4 when `wide`=1;
  - the second read is issued only after the first read's data has returned.
- R7: With `wide`=0, the value and both limits are compared as signed 16-bit numbers in bits [15:0]. Bits [31:16] of `test_val` and of the read data have no effect on the result.
- R8: With `wide`=1, the comparison is a full 32-bit signed comparison. For example, 5 lies above the range [-100, -10].
- R9: Each accepted operation ends with exactly one of `trap_valid` or `done`, high for a single cycle. A `start` seen while an operation is in progress is ignored and produces no extra result.
- R10: After reset, `trap_valid`, `done`, `bad_operand` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_bound | input | 1 | 1 = bounds check, 0 = overflow check |
| of_flag | input | 1 | Overflow flag for the overflow check |
| lim_is_reg | input | 1 | Limit operand is encoded as a register |
| wide | input | 1 | 1 = 32-bit operands, 0 = 16-bit |
| test_val | input | DW | Value to test |
| base_addr | input | AW | Byte address of the lower limit |
| mem_req | output | 1 | Read request, one cycle |
| mem_addr | output | AW | Read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| trap_valid | output | 1 | Trap request pulse |
| trap_vec | output | 8 | Trap vector, valid with `trap_valid` |
| bad_operand | output | 1 | Invalid-operand indication, pulses with vector 6 |
| done | output | 1 | Completed with no trap |

## Verification
A wrong state shows at the memory port first:

- A sequencer stuck in the wrong state, or one that skipped a state, shows as a missing read, an extra read or a wrong address. This appears within a cycle of the expected request.
- A wrong latched limit or operand size shows as a wrong verdict when `ST_FINISH` is reached, a few cycles after the second read returns.

Operations are chosen so that signed and unsigned comparison disagree, and so that 16-bit and 32-bit interpretation disagree. A swapped sign treatment or a dropped width select therefore changes the reported vector.

// File: rtl/trap_pkg.sv
package trap_pkg;
    localparam logic [7:0] VEC_OVERFLOW = 8'h04;
    localparam logic [7:0] VEC_RANGE    = 8'h05;
    localparam logic [7:0] VEC_BADOP    = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_LO,
        ST_WAIT_LO,
        ST_REQ_HI,
        ST_WAIT_HI,
        ST_EVAL,
        ST_FINISH
    } seq_state_t;

    typedef struct packed {
        logic       trap;
        logic [7:0] vec;
        logic       bad;
    } verdict_t;
endpackage

// File: rtl/trap_limit_cmp.sv
module trap_limit_cmp #(
    parameter int DW = 32
) (
    input  logic          wide,
    input  logic [DW-1:0] value,
    input  logic [DW-1:0] lim_lo,
    input  logic [DW-1:0] lim_hi,
    output logic          out_of_range
);
    localparam int HW = DW / 2;

    logic signed [DW-1:0] v_ext, lo_ext, hi_ext;

    generate
        if (HW > 0) begin : g_dual_width
            always_comb begin
                if (wide) begin
                    v_ext  = value;
                    lo_ext = lim_lo;
                    hi_ext = lim_hi;
                end else begin
                    v_ext  = {{(DW-HW){value[HW-1]}},  value[HW-1:0]};
                    lo_ext = {{(DW-HW){lim_lo[HW-1]}}, lim_lo[HW-1:0]};
                    hi_ext = {{(DW-HW){lim_hi[HW-1]}}, lim_hi[HW-1:0]};
                end
            end
        end else begin : g_single_width
            assign v_ext  = value;
            assign lo_ext = lim_lo;
            assign hi_ext = lim_hi;
        end
    endgenerate

    assign out_of_range = (v_ext < lo_ext) || (v_ext > hi_ext);

    always_comb begin
        if (!$isunknown({v_ext, lo_ext, hi_ext}) && (v_ext == lo_ext || v_ext == hi_ext))
            AST_LIMIT_INCLUSIVE: assert (!out_of_range || lo_ext > hi_ext); // R4
    end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
    import trap_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       op_bound,
    input  logic       of_flag,
    input  logic       lim_is_reg,
    input  logic       mem_rvalid,
    input  logic       out_of_range,
    output logic       accept,
    output logic       cap_lo,
    output logic       cap_hi,
    output logic       mem_req,
    output logic       sel_hi,
    output logic       trap_valid,
    output logic [7:0] trap_vec,
    output logic       bad_operand,
    output logic       done
);
    seq_state_t state, state_nx;
    verdict_t   verdict_q, verdict_nx;
    logic       verdict_ld;

    // next state and verdict
    always_comb begin
        state_nx   = state;
        verdict_nx = '0;
        verdict_ld = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    if (!op_bound) begin
                        state_nx   = ST_FINISH;
                        verdict_ld = 1'b1;
                        verdict_nx = of_flag ? '{trap: 1'b1, vec: VEC_OVERFLOW, bad: 1'b0} : '0;
                    end else if (lim_is_reg) begin
                        state_nx   = ST_FINISH;
                        verdict_ld = 1'b1;
                        verdict_nx = '{trap: 1'b1, vec: VEC_BADOP, bad: 1'b1};
                    end else begin
                        state_nx = ST_REQ_LO;
                    end
                end
            end
            ST_REQ_LO:  state_nx = ST_WAIT_LO;
            ST_WAIT_LO: if (mem_rvalid) state_nx = ST_REQ_HI;
            ST_REQ_HI:  state_nx = ST_WAIT_HI;
            ST_WAIT_HI: if (mem_rvalid) state_nx = ST_EVAL;
            ST_EVAL: begin
                state_nx   = ST_FINISH;
                verdict_ld = 1'b1;
                verdict_nx = out_of_range ? '{trap: 1'b1, vec: VEC_RANGE, bad: 1'b0} : '0;
            end
            ST_FINISH:  state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            verdict_q <= '0;
        end else begin
            state <= state_nx;
            if (verdict_ld) verdict_q <= verdict_nx;
        end
    end

    // outputs
    always_comb begin
        accept      = 1'b0;
        cap_lo      = 1'b0;
        cap_hi      = 1'b0;
        mem_req     = 1'b0;
        sel_hi      = 1'b0;
        trap_valid  = 1'b0;
        trap_vec    = 8'h00;
        bad_operand = 1'b0;
        done        = 1'b0;
        unique case (state)
            ST_IDLE:    accept = start;
            ST_REQ_LO:  mem_req = 1'b1;
            ST_WAIT_LO: cap_lo = mem_rvalid;
            ST_REQ_HI: begin
                mem_req = 1'b1;
                sel_hi  = 1'b1;
            end
            ST_WAIT_HI: cap_hi = mem_rvalid;
            ST_EVAL:    ;
            ST_FINISH: begin
                trap_valid  = verdict_q.trap;
                trap_vec    = verdict_q.trap ? verdict_q.vec : 8'h00;
                bad_operand = verdict_q.bad;
                done        = !verdict_q.trap;
            end
            default: ;
        endcase
    end

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_valid && done)); // R9
    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_valid || done) |=> !(trap_valid || done)); // R9
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req); // R6
    AST_BAD_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        bad_operand |-> (trap_valid && trap_vec == VEC_BADOP)); // R5
    AST_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> (trap_vec == VEC_OVERFLOW || trap_vec == VEC_RANGE || trap_vec == VEC_BADOP)); // R3
endmodule

// File: rtl/trap_checker.sv
module trap_checker #(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          op_bound,
    input  logic          of_flag,
    input  logic          lim_is_reg,
    input  logic          wide,
    input  logic [DW-1:0] test_val,
    input  logic [AW-1:0] base_addr,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata,
    output logic          trap_valid,
    output logic [7:0]    trap_vec,
    output logic          bad_operand,
    output logic          done
);
    localparam int          FULL_BYTES = DW / 8;
    localparam int          HALF_BYTES = DW / 16;
    localparam logic [AW-1:0] STEP_FULL = AW'(FULL_BYTES);
    localparam logic [AW-1:0] STEP_HALF = AW'(HALF_BYTES);

    logic          accept, cap_lo, cap_hi, sel_hi, out_of_range;
    logic [DW-1:0] val_q, lo_q, hi_q;
    logic [AW-1:0] base_q;
    logic          wide_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q  <= '0;
            base_q <= '0;
            wide_q <= 1'b0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else begin
            if (accept) begin
                val_q  <= test_val;
                base_q <= base_addr;
                wide_q <= wide;
            end
            if (cap_lo) lo_q <= mem_rdata;
            if (cap_hi) hi_q <= mem_rdata;
        end
    end

    assign mem_addr = sel_hi ? base_q + (wide_q ? STEP_FULL : STEP_HALF) : base_q;

    trap_limit_cmp #(.DW(DW)) u_cmp (
        .wide         (wide_q),
        .value        (val_q),
        .lim_lo       (lo_q),
        .lim_hi       (hi_q),
        .out_of_range (out_of_range)
    );

    trap_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .op_bound     (op_bound),
        .of_flag      (of_flag),
        .lim_is_reg   (lim_is_reg),
        .mem_rvalid   (mem_rvalid),
        .out_of_range (out_of_range),
        .accept       (accept),
        .cap_lo       (cap_lo),
        .cap_hi       (cap_hi),
        .mem_req      (mem_req),
        .sel_hi       (sel_hi),
        .trap_valid   (trap_valid),
        .trap_vec     (trap_vec),
        .bad_operand  (bad_operand),
        .done         (done)
    );

    AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr != base_q) |-> (mem_addr == base_q + STEP_HALF || mem_addr == base_q + STEP_FULL)); // R6
endmodule

// File: tb/trap_checker_bench.sv
module trap_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, op_bound = 1'b0, of_flag = 1'b0, lim_is_reg = 1'b0, wide = 1'b0;
    logic [31:0] test_val = '0, base_addr = '0;
    logic        mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic        trap_valid, bad_operand, done;
    logic [7:0]  trap_vec;

    typedef struct {
        logic       trap;
        logic [7:0] vec;
        logic       bad;
        string      req;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    string       addr_tag_q[$];
    logic [31:0] mem [logic [31:0]];
    int          n_checks = 0, n_fail = 0, n_res = 0;
    logic        p1_valid = 1'b0;
    logic [31:0] p1_addr = '0;

    always #5 clk = ~clk;

    trap_checker u_trap_checker (
        .clk(clk), .rst_n(rst_n), .start(start), .op_bound(op_bound), .of_flag(of_flag),
        .lim_is_reg(lim_is_reg), .wide(wide), .test_val(test_val), .base_addr(base_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .trap_valid(trap_valid), .trap_vec(trap_vec), .bad_operand(bad_operand), .done(done)
    );

    // memory model, two-cycle read latency
    always @(posedge clk) begin
        p1_valid   <= mem_req;
        p1_addr    <= mem_addr;
        mem_rvalid <= p1_valid;
        mem_rdata  <= mem.exists(p1_addr) ? mem[p1_addr] : 32'h0;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // monitor: results and memory requests
    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (addr_q.size() == 0) begin
                check(0, "R6", "unexpected read", mem_addr, 32'h0);
            end else begin
                logic [31:0] ea;
                string       et;
                ea = addr_q.pop_front();
                et = addr_tag_q.pop_front();
                check(mem_addr == ea, et, "read address", mem_addr, ea);
            end
        end
        if (rst_n && (trap_valid || done)) begin
            n_res++;
            if (exp_q.size() == 0) begin
                check(0, "R9", "extra result", {trap_valid, done}, 32'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(trap_valid == e.trap && done == !e.trap, e.req, "trap/done",
                      {trap_valid, done}, {e.trap, !e.trap});
                if (e.trap)
                    check(trap_vec == e.vec, e.req, "vector", trap_vec, e.vec);
                check(bad_operand == e.bad, e.req, "bad_operand", bad_operand, e.bad);
            end
        end
    end

    function automatic logic exp_out(input logic w, input logic [31:0] v,
                                     input logic [31:0] lo, input logic [31:0] hi);
        int sv, sl, sh;
        if (w) begin
            sv = $signed(v);  sl = $signed(lo);  sh = $signed(hi);
        end else begin
            sv = $signed(v[15:0]);  sl = $signed(lo[15:0]);  sh = $signed(hi[15:0]);
        end
        return (sv < sl) || (sv > sh);
    endfunction

    task automatic run_op(input logic bnd, input logic ovf, input logic w, input logic isreg,
                          input logic [31:0] v, input logic [31:0] base,
                          input logic [31:0] lo, input logic [31:0] hi,
                          input string req, input bit poke_busy);
        exp_t e;
        int   target;
        e.req = req;
        if (!bnd) begin
            e.trap = ovf;  e.vec = 8'h04;  e.bad = 1'b0;
        end else if (isreg) begin
            e.trap = 1'b1; e.vec = 8'h06;  e.bad = 1'b1;
        end else begin
            mem[base] = lo;
            mem[base + (w ? 32'd4 : 32'd2)] = hi;
            e.trap = exp_out(w, v, lo, hi);  e.vec = 8'h05;  e.bad = 1'b0;
            addr_q.push_back(base);                       addr_tag_q.push_back("R6");
            addr_q.push_back(base + (w ? 32'd4 : 32'd2)); addr_tag_q.push_back("R6");
        end
        exp_q.push_back(e);
        target = n_res + 1;
        @(negedge clk);
        start = 1'b1; op_bound = bnd; of_flag = ovf; wide = w; lim_is_reg = isreg;
        test_val = v; base_addr = base;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R9: start during a bounds check is ignored, inputs changed too
            @(negedge clk);
            start = 1'b1; op_bound = 1'b0; of_flag = 1'b1; wide = ~w; test_val = 32'h0;
            @(negedge clk);
            start = 1'b0;
        end
        wait (n_res >= target);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run;
        check(exp_q.size() == 0 && addr_q.size() == 0, "R9", "pending items",
              exp_q.size() + addr_q.size(), 32'h0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", n_res, exp_q.size());
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check(!trap_valid && !done && !bad_operand && !mem_req, "R10", "reset outputs",
              {trap_valid, done, bad_operand, mem_req}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!trap_valid && !done && !mem_req, "R10", "idle after reset",
              {trap_valid, done, mem_req}, 32'h0);

        run_op(0, 1, 1, 0, 32'h0, 32'h0, 32'h0, 32'h0, "R1", 0);
        run_op(0, 0, 1, 0, 32'h0, 32'h0, 32'h0, 32'h0, "R2", 0);
        run_op(1, 0, 1, 1, 32'h5, 32'h300, 32'h0, 32'h0, "R5", 0);
        run_op(1, 0, 1, 0, 32'd50, 32'h200, 32'd10, 32'd100, "R4", 0);
        run_op(1, 0, 1, 0, 32'd9, 32'h210, 32'd10, 32'd100, "R3", 0);
        run_op(1, 0, 1, 0, 32'd101, 32'h220, 32'd10, 32'd100, "R3", 0);
        run_op(1, 0, 1, 0, 32'd10, 32'h230, 32'd10, 32'd100, "R4", 0);
        run_op(1, 0, 1, 0, 32'd100, 32'h240, 32'd10, 32'd100, "R4", 0);
        run_op(1, 0, 1, 0, -32'sd50, 32'h250, -32'sd100, -32'sd10, "R8", 0);
        run_op(1, 0, 1, 0, 32'd5, 32'h260, -32'sd100, -32'sd10, "R8", 0);
        run_op(1, 0, 1, 0, 32'h8000_0000, 32'h270, 32'h0, 32'h7FFF_FFFF, "R8", 0);
        // 16-bit: limits [-16, 16], garbage upper halves
        run_op(1, 0, 0, 0, 32'h1234_FFF8, 32'h100, 32'hABCD_FFF0, 32'h5A5A_0010, "R7", 0);
        run_op(1, 0, 0, 0, 32'h0000_0020, 32'h110, 32'hABCD_FFF0, 32'h5A5A_0010, "R7", 0);
        run_op(1, 0, 0, 0, 32'h7FFF_0005, 32'h120, 32'hFFFF_FFF0, 32'h0000_0010, "R7", 0);
        run_op(1, 0, 0, 0, 32'h0000_FFF0, 32'h130, 32'h0000_FFF0, 32'h0000_0010, "R4", 0);
        run_op(1, 0, 1, 0, 32'd55, 32'h400, 32'd10, 32'd50, "R9", 1);
        run_op(1, 0, 1, 0, 32'd30, 32'h410, 32'd10, 32'd50, "R9", 1);
        finish_run();
    end
endmodule